// File: doc/BRIEF.md
# Tuner Control Register Slave

This block is a two-wire serial slave that holds twelve 8-bit control words for a frequency synthesizer front end and answers reads with a single status byte. The serial clock and data lines arrive already synchronized to the system clock. The block samples both lines on every system clock and finds bus edges and START/STOP conditions itself. It drives the data line only through a pull-low enable, which the pad turns into an open-drain output.

A host writes by sending the device address with the direction bit cleared, then one pointer byte, then any number of data bytes. After each data byte the pointer steps forward by one. Every completed write gives a one-cycle strobe with the register index and the value, and the parallel register image changes on the following clock. The write strobe is a plain event with no back-pressure. A write is a bus event that cannot be held off, so the strobe has no ready input. Any consumer must take it in the cycle it is high. A read returns a byte built from the lock flag and the sub-band code. The byte is sent again for as long as the host acknowledges it.

Top module: `tuner_i2c_regbank`

## Requirements
- R1: After reset all twelve registers read 0x00, the pull-low enable is inactive and no write strobe is issued.
- R2: The slave answers only to the 7-bit address 1100_0 followed by the two address-select bits, with the direction bit as the LSB of the address byte (0 = write, 1 = read). On a matching address it pulls SDA low during the ninth clock. On any other address it leaves SDA released and ignores the bytes that follow, up to the next START.
- R3: In a write, the second byte sets the register pointer. Each later byte, taken MSB first on SCL rising edges, is acknowledged and stored at the pointer. A one-cycle write strobe carries the index and the byte, and the register image shows the new value on the next clock.
- R4: After each data byte the pointer advances by one, so a burst fills consecutive registers. Only the first byte after the address is taken as a pointer.
- R5: Data bytes aimed at pointer values 0x0C to 0xFF are acknowledged but change no register and raise no strobe. The pointer wraps from 0xFF to 0x00.
- R6: A read returns a status byte with the lock flag in bit 7, the 3-bit sub-band code in bits 5:3, and zeros in bits 6 and 2:0. The inputs are sampled as each byte starts. The byte is sent again after a host ACK. After a host NACK the slave releases SDA and goes idle.
- R7: A START or STOP at any point abandons the partly received byte, and no register changes. After a START the next byte is taken as an address.
- R8: The pull-low enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock, synchronized |
| sda_i | input | 1 | Serial data as seen on the bus, synchronized |
| dev_sel_i | input | 2 | Low two bits of the device address |
| pll_lock_i | input | 1 | Synthesizer lock flag for the status byte |
| sub_band_i | input | 3 | VCO sub-band code for the status byte |
| sda_pull_o | output | 1 | 1 = drive SDA low, 0 = release |
| regs_o | output | 96 | Register image, register k in bits 8k+7:8k |
| wr_stb_o | output | 1 | One-cycle pulse per stored byte |
| wr_idx_o | output | 4 | Register index of the strobed write |
| wr_data_o | output | 8 | Byte value of the strobed write |

## Verification
The assertions take for granted that each SCL level lasts at least three system clocks. They also assume the host changes SDA only while SCL is low, except when it makes a START or STOP, and never drives SDA low while the slave is expected to drive it. The bench's bus model holds every SCL phase for four clocks and changes SDA only on low phases. The line it feeds back is the wired-AND of the host's drive and the slave's pull-low enable, so the slave samples its own acknowledge as a real bus would.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_PTR,
    LK_DATA,
    LK_READ
  } link_st_e;

  // status layout: lock in bit 7, sub band in bits 5:3, rest zero
  function automatic logic [7:0] build_status(input logic lock, input logic [2:0] band);
    return {lock, 1'b0, band, 3'b000};
  endfunction

endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
  import tuner_i2c_pkg::*;
#(
  parameter int          NUM_REGS = 12,
  parameter int          DW       = 8,
  parameter logic [4:0]  DEV_HI   = 5'b11000,
  localparam int         IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [1:0]       dev_sel_i,
  input  logic             pll_lock_i,
  input  logic [2:0]       sub_band_i,
  output logic             sda_pull_o,
  output logic             wr_stb_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [DW-1:0]    wr_data_o
);

  localparam int CNT_W = $clog2(DW + 1);

  link_st_e         st_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic             in_ack_q;
  logic [DW-1:0]    rx_q;
  logic [DW-1:0]    tx_q;
  logic             pull_q;
  logic [7:0]       ptr_q;
  logic             rd_go_q;
  logic             stb_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    data_q;

  logic          byte_done;
  logic          addr_hit;
  logic [7:0]    stat_now;

  assign byte_done = (bit_cnt_q == CNT_W'(DW));
  assign addr_hit  = (rx_q[7:1] == {DEV_HI, dev_sel_i});
  assign stat_now  = build_status(pll_lock_i, sub_band_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= LK_IDLE;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      rx_q      <= '0;
      tx_q      <= '0;
      pull_q    <= 1'b0;
      ptr_q     <= '0;
      rd_go_q   <= 1'b0;
      stb_q     <= 1'b0;
      idx_q     <= '0;
      data_q    <= '0;
    end else begin
      stb_q <= 1'b0;
      if (start_i) begin
        st_q      <= LK_ADDR;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        pull_q    <= 1'b0;
      end else if (stop_i) begin
        st_q      <= LK_IDLE;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        pull_q    <= 1'b0;
      end else if (st_q != LK_IDLE) begin
        if (scl_rise_i) begin
          if (in_ack_q) begin
            if (st_q == LK_READ) rd_go_q <= ~sda_i;
          end else begin
            if (st_q != LK_READ) rx_q <= {rx_q[DW-2:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end else if (scl_fall_i) begin
          if (in_ack_q) begin
            in_ack_q  <= 1'b0;
            bit_cnt_q <= '0;
            if (st_q == LK_READ) begin
              if (rd_go_q) begin
                tx_q   <= {stat_now[6:0], 1'b0};
                pull_q <= ~stat_now[7];
              end else begin
                pull_q <= 1'b0;
                st_q   <= LK_IDLE;
              end
            end else begin
              pull_q <= 1'b0;
            end
          end else if (byte_done) begin
            in_ack_q <= 1'b1;
            unique case (st_q)
              LK_ADDR: begin
                if (addr_hit) begin
                  pull_q <= 1'b1;
                  st_q   <= rx_q[0] ? LK_READ : LK_PTR;
                end else begin
                  pull_q <= 1'b0;
                  st_q   <= LK_IDLE;
                end
              end
              LK_PTR: begin
                ptr_q  <= rx_q;
                pull_q <= 1'b1;
                st_q   <= LK_DATA;
              end
              LK_DATA: begin
                pull_q <= 1'b1;
                ptr_q  <= ptr_q + 8'd1;
                if (32'(ptr_q) < NUM_REGS) begin
                  stb_q  <= 1'b1;
                  idx_q  <= ptr_q[IDX_W-1:0];
                  data_q <= rx_q;
                end
              end
              default: pull_q <= 1'b0;
            endcase
          end else if (st_q == LK_READ) begin
            pull_q <= ~tx_q[DW-1];
            tx_q   <= {tx_q[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_stb_o   = stb_q;
  assign wr_idx_o   = idx_q;
  assign wr_data_o  = data_q;

  // R3
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  // R5
  stb_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (32'(wr_idx_o) < NUM_REGS));

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i || start_i) |=> !sda_pull_o);

  // R8
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank #(
  parameter int NUM_REGS = 12,
  parameter int DW       = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_stb_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [DW-1:0]          wr_data_i,
  output logic [NUM_REGS*DW-1:0] regs_o
);

  logic [DW-1:0] mem_q [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[k] <= '0;
      else if (wr_stb_i && (wr_idx_i == IDX_W'(k))) mem_q[k] <= wr_data_i;
    end
    assign regs_o[k*DW +: DW] = mem_q[k];
  end

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_i |=> (mem_q[$past(wr_idx_i)] == $past(wr_data_i)));

  // R5
  hold_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb_i |=> $stable(regs_o));

endmodule

// File: rtl/tuner_i2c_regbank.sv
module tuner_i2c_regbank #(
  parameter int         NUM_REGS = 12,
  parameter int         DW       = 8,
  parameter logic [4:0] DEV_HI   = 5'b11000,
  localparam int        IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic [1:0]             dev_sel_i,
  input  logic                   pll_lock_i,
  input  logic [2:0]             sub_band_i,
  output logic                   sda_pull_o,
  output logic [NUM_REGS*DW-1:0] regs_o,
  output logic                   wr_stb_o,
  output logic [IDX_W-1:0]       wr_idx_o,
  output logic [DW-1:0]          wr_data_o
);

  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_events u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  i2c_link_fsm #(
    .NUM_REGS (NUM_REGS),
    .DW       (DW),
    .DEV_HI   (DEV_HI)
  ) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .dev_sel_i  (dev_sel_i),
    .pll_lock_i (pll_lock_i),
    .sub_band_i (sub_band_i),
    .sda_pull_o (sda_pull_o),
    .wr_stb_o   (wr_stb_o),
    .wr_idx_o   (wr_idx_o),
    .wr_data_o  (wr_data_o)
  );

  tuner_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .DW       (DW)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb_i  (wr_stb_o),
    .wr_idx_i  (wr_idx_o),
    .wr_data_i (wr_data_o),
    .regs_o    (regs_o)
  );

endmodule

// File: tb/test_tuner_i2c_regbank.sv
module test_tuner_i2c_regbank;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic [1:0]  dev_sel = 2'd2;
  logic        lock = 1'b0;
  logic [2:0]  band = 3'd0;
  logic        sda_pull;
  logic [95:0] regs;
  logic        wr_stb;
  logic [3:0]  wr_idx;
  logic [7:0]  wr_data;
  logic        sda_bus;

  int n_chk = 0;
  int n_bad = 0;
  int n_stb = 0;
  int r8_bad = 0;
  logic pull_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  tuner_i2c_regbank i_tuner_i2c_regbank (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_bus),
    .dev_sel_i  (dev_sel),
    .pll_lock_i (lock),
    .sub_band_i (band),
    .sda_pull_o (sda_pull),
    .regs_o     (regs),
    .wr_stb_o   (wr_stb),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  always @(negedge clk) begin
    if (wr_stb) n_stb++;
    if (sda_pull != pull_prev && m_scl) r8_bad++;
    pull_prev = sda_pull;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wait_clk(1); m_scl = 1'b0; wait_clk(HALF);
    m_sda = 1'b1; wait_clk(HALF);
    m_scl = 1'b1; wait_clk(HALF);
    m_sda = 1'b0; wait_clk(HALF);
    m_scl = 1'b0; wait_clk(HALF);
  endtask

  task automatic bus_stop();
    wait_clk(1); m_scl = 1'b0; wait_clk(HALF);
    m_sda = 1'b0; wait_clk(HALF);
    m_scl = 1'b1; wait_clk(HALF);
    m_sda = 1'b1; wait_clk(HALF);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; wait_clk(HALF);
    m_scl = 1'b1; wait_clk(HALF);
    m_scl = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) bit_out(b[i]);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; wait_clk(HALF);
    m_scl = 1'b1; wait_clk(HALF/2);
    ack = ~sda_bus;
    wait_clk(HALF - HALF/2);
    m_scl = 1'b0;
  endtask

  task automatic read_byte(input logic host_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wait_clk(HALF);
      m_scl = 1'b1; wait_clk(HALF/2);
      d[i] = sda_bus;
      wait_clk(HALF - HALF/2);
      m_scl = 1'b0;
    end
    m_sda = ~host_ack; wait_clk(HALF);
    m_scl = 1'b1; wait_clk(HALF);
    m_scl = 1'b0;
  endtask

  function automatic int reg_at(input int k);
    return int'(regs[k*8 +: 8]);
  endfunction

  task automatic t_reset();
    for (int k = 0; k < 12; k++) chk("R1 reset register", reg_at(k), 0);
    chk("R1 reset pull", int'(sda_pull), 0);
    chk("R1 reset strobe", n_stb, 0);
  endtask

  task automatic t_wrong_addr();
    logic a;
    n_stb = 0;
    bus_start();
    send_byte(8'hC2, a);
    chk("R2 no ack on other address", int'(a), 0);
    send_byte(8'h00, a);
    send_byte(8'h55, a);
    chk("R2 following byte ignored ack", int'(a), 0);
    bus_stop();
    chk("R2 register untouched", reg_at(0), 0);
    chk("R2 no strobe", n_stb, 0);
  endtask

  task automatic t_burst();
    logic a0, a1, a2, a3, a4;
    n_stb = 0;
    bus_start();
    send_byte(8'hC4, a0);
    send_byte(8'h02, a1);
    send_byte(8'hA1, a2);
    send_byte(8'hB2, a3);
    send_byte(8'hC3, a4);
    bus_stop();
    chk("R2 address ack", int'(a0), 1);
    chk("R3 pointer ack", int'(a1), 1);
    chk("R3 data ack", int'(a2 & a3 & a4), 1);
    chk("R4 reg2", reg_at(2), 8'hA1);
    chk("R4 reg3", reg_at(3), 8'hB2);
    chk("R4 reg4", reg_at(4), 8'hC3);
    chk("R3 strobe count", n_stb, 3);
  endtask

  task automatic t_single();
    logic a;
    n_stb = 0;
    bus_start();
    send_byte(8'hC4, a);
    send_byte(8'h00, a);
    send_byte(8'h5A, a);
    bus_stop();
    chk("R3 MSB-first byte", reg_at(0), 8'h5A);
    chk("R3 single strobe", n_stb, 1);
  endtask

  task automatic t_range();
    logic a;
    n_stb = 0;
    bus_start();
    send_byte(8'hC4, a);
    send_byte(8'h0A, a);
    send_byte(8'h01, a);
    send_byte(8'h02, a);
    send_byte(8'h03, a);
    chk("R5 ack beyond last register", int'(a), 1);
    bus_stop();
    chk("R5 reg10", reg_at(10), 8'h01);
    chk("R5 reg11", reg_at(11), 8'h02);
    chk("R5 reg0 unchanged", reg_at(0), 8'h5A);
    chk("R5 strobes only in range", n_stb, 2);
  endtask

  task automatic t_wrap();
    logic a;
    n_stb = 0;
    bus_start();
    send_byte(8'hC4, a);
    send_byte(8'hFF, a);
    send_byte(8'hEE, a);
    send_byte(8'h77, a);
    bus_stop();
    chk("R5 wrap to reg0", reg_at(0), 8'h77);
    chk("R5 wrap strobe count", n_stb, 1);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    dev_sel = 2'd1;
    lock = 1'b1; band = 3'd5;
    bus_start();
    send_byte(8'hC3, a);
    chk("R2 read address ack", int'(a), 1);
    read_byte(1'b1, d);
    chk("R6 status byte", int'(d), 8'hA8);
    read_byte(1'b0, d);
    chk("R6 repeat after host ack", int'(d), 8'hA8);
    wait_clk(2);
    chk("R6 released after NACK", int'(sda_pull), 0);
    bus_stop();
    lock = 1'b0; band = 3'd2;
    bus_start();
    send_byte(8'hC3, a);
    read_byte(1'b0, d);
    chk("R6 status byte unlocked", int'(d), 8'h10);
    bus_stop();
    dev_sel = 2'd2;
  endtask

  task automatic t_abort();
    logic a;
    n_stb = 0;
    bus_start();
    send_bits(8'hC4, 4);
    bus_start();
    send_byte(8'hC4, a);
    chk("R7 address after restart", int'(a), 1);
    send_byte(8'h01, a);
    send_byte(8'h3C, a);
    bus_stop();
    chk("R7 write after restart", reg_at(1), 8'h3C);
    n_stb = 0;
    bus_start();
    send_byte(8'hC4, a);
    send_byte(8'h05, a);
    send_bits(8'hFF, 3);
    bus_stop();
    chk("R7 partial byte dropped", reg_at(5), 0);
    chk("R7 no strobe on partial", n_stb, 0);
    chk("R8 pull changed only with SCL low", r8_bad, 0);
  endtask

  bit done = 1'b0;

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_wrong_addr();
    t_burst();
    t_single();
    t_range();
    t_wrap();
    t_read();
    t_abort();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule